// File: doc/BRIEF.md
# I2C Indirect-Access Register Telegram Slave

This block is the I2C slave front end of a peripheral whose internal memory is reached only through indirect telegrams. A two-bit strap picks one of three device address pairs, so that up to three such peripherals can share one bus. A write telegram carries a subaddress byte, a 16-bit internal address and a 16-bit data word. A read telegram carries the subaddress and the address. It is then turned around with a repeated START and the read address, and the slave returns a 16-bit word.

Each complete telegram becomes one request on a simple request/acknowledge port towards the internal side. While that request is pending, the slave holds SCL low. If no acknowledge comes within a bounded wait, the slave releases both lines. It then records an error and refuses every remaining acknowledge of the transfer.

Subaddress 0x00 is a local control word. Bit 15 of this word reports that a reset has happened. Bit 14 reports that a wait timeout has occurred. Writing a word with bit 15 set performs a software reset. SCL and SDA are open-drain: the block only drives enables that pull a line low, and it samples both lines through two-flop synchronizers.

Top module: `i2c_telegram_slave`

## Requirements
- R1: The strap code selects the device address: 2'b00 answers 0x80 (write) and 0x81 (read), 2'b01 answers 0x84/0x85, and 2'b10 or 2'b11 answers 0x88/0x89. Any other address byte after START is not acknowledged, and the slave stays silent until the next START or STOP.
- R2: A write telegram is the write address, a subaddress of 0x10 or 0x12, the address high and low bytes, then the data high and low bytes. Every byte is ACKed. Exactly one request is issued with req_write=1 and the received subaddress, address and data, and the request fields stay stable while it is pending.
- R3: A read telegram is the write address, subaddress 0x11 or 0x13, and the two address bytes, followed by a repeated START and the read address. It issues one request with req_write=0, and then returns the acknowledged req_rdata high byte first, each byte MSB first.
- R4: Only the subaddresses 0x00, 0x10, 0x11, 0x12 and 0x13 are ACKed. Any other subaddress is NACKed, every later byte is NACKed until the next START or STOP, and no request is issued.
- R5: From the falling SCL edge that ends the last byte of a telegram until the internal acknowledge, SCL is held low. req_valid is never high without SCL being held.
- R6: With hw_err_i low, an unacknowledged request is abandoned after NORM_WAIT_CYC cycles of held SCL. SCL and SDA are then released and req_valid drops.
- R7: With hw_err_i high, the wait limit is ERR_WAIT_CYC cycles instead of NORM_WAIT_CYC.
- R8: After a timeout, every remaining acknowledge bit of the transfer is left high, including the ACK of a read address after a repeated START, until a STOP is seen.
- R9: A read of subaddress 0x00 returns {reset flag, error flag, 14'b0}. A timeout sets the error flag (bit 14).
- R10: The reset flag (bit 15) is 1 after hardware reset and after a software reset. It is cleared when a CONTROL read is addressed, so the next CONTROL read shows 0 there.
- R11: A CONTROL write with data bit 15 set is a software reset: it clears bit 14, sets bit 15 and issues no internal request. A CONTROL write with bit 15 clear changes neither flag.
- R12: Any byte after the sixth byte of a write telegram is NACKed, and it causes no further request.
- R13: During and right after reset, SCL and SDA are released and no request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_sel | input | 2 | Decoded address strap: 00 low, 01 high, 1x open |
| hw_err_i | input | 1 | Internal hardware error, selects the long wait limit |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK or data zero) |
| req_valid | output | 1 | Internal request pending |
| req_write | output | 1 | Request is a write (1) or a read (0) |
| req_sub | output | 8 | Subaddress of the request |
| req_addr | output | 16 | Internal address |
| req_wdata | output | 16 | Write data |
| req_ack | input | 1 | Internal side completes the request |
| req_rdata | input | 16 | Read data, valid with req_ack |

## Verification
The bench drives a bit-level master that honours clock stretching, and an internal responder with random acknowledge latency. It targets the repeated-START turnaround, where an engine that misses the restart would shift the address bits into a stale byte. It also targets the two timeout limits, which are checked by the length of the held-SCL interval; a timer that never fires would hang the bus. Other cases are the forced NACK of a read address after a timeout, the sixth-plus byte, and unlisted subaddresses, where a faulty design would issue spurious requests. Finally, the bench runs the flag sequence of the control word: set on reset, cleared by a read, set by a software reset, error cleared only by a software reset.

// File: rtl/i2c_tel_pkg.sv
package i2c_tel_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [BYTE_W-1:0] SUB_CTRL   = 8'h00;
    localparam logic [BYTE_W-1:0] SUB_DEM_WR = 8'h10;
    localparam logic [BYTE_W-1:0] SUB_DEM_RD = 8'h11;
    localparam logic [BYTE_W-1:0] SUB_DSP_WR = 8'h12;
    localparam logic [BYTE_W-1:0] SUB_DSP_RD = 8'h13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_WAIT,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } link_st_e;

    typedef enum logic [2:0] {
        PH_DEV,
        PH_SUB,
        PH_AHI,
        PH_ALO,
        PH_DHI,
        PH_DLO,
        PH_DONE
    } tel_ph_e;

    typedef struct packed {
        link_st_e           st;
        tel_ph_e            ph;
        logic [3:0]         bitcnt;
        logic [BYTE_W-1:0]  shreg;
        logic [BYTE_W-1:0]  sub;
        logic [WORD_W-1:0]  addr;
        logic [WORD_W-1:0]  wdata;
        logic [WORD_W-1:0]  rdbuf;
        logic               tx_mode;
        logic               tx_lo;
        logic               mack_ok;
        logic               sda_oe;
        logic               scl_oe;
        logic               req_valid;
        logic               req_write;
        logic               xfer_err;
        logic               ctl_rst;
        logic               ctl_err;
    } tel_regs_t;

    function automatic logic [6:0] dev_base(input logic [1:0] strap);
        case (strap)
            2'b00:   return 7'h40;
            2'b01:   return 7'h42;
            default: return 7'h44;
        endcase
    endfunction

    function automatic logic sub_is_rd(input logic [BYTE_W-1:0] s);
        return (s == SUB_DEM_RD) || (s == SUB_DSP_RD);
    endfunction

    function automatic logic sub_is_wr(input logic [BYTE_W-1:0] s);
        return (s == SUB_DEM_WR) || (s == SUB_DSP_WR);
    endfunction

    function automatic logic sub_known(input logic [BYTE_W-1:0] s);
        return sub_is_rd(s) || sub_is_wr(s) || (s == SUB_CTRL);
    endfunction

endpackage

// File: rtl/i2c_tel_line_sync.sv
module i2c_tel_line_sync #(
    parameter int N_LINES = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_i,
    output logic [N_LINES-1:0] line_o,
    output logic [N_LINES-1:0] line_prev_o
);

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [STAGES:0] pipe_q;
        logic [STAGES:0] pipe_d;

        always_comb begin
            pipe_d = {pipe_q[STAGES-1:0], line_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= '1;
            end else begin
                pipe_q <= pipe_d;
            end
        end

        assign line_o[g]      = pipe_q[STAGES-1];
        assign line_prev_o[g] = pipe_q[STAGES];
    end

endmodule

// File: rtl/i2c_tel_wait_timer.sv
module i2c_tel_wait_timer #(
    parameter int NORM_WAIT_CYC = 50000,
    parameter int ERR_WAIT_CYC  = 90000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic long_i,
    output logic expired_o
);

    localparam int CNT_W = $clog2(ERR_WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] NORM_LIM = CNT_W'(NORM_WAIT_CYC);
    localparam logic [CNT_W-1:0] ERR_LIM  = CNT_W'(ERR_WAIT_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit     = long_i ? ERR_LIM : NORM_LIM;
        expired_o = run_i && (cnt_q >= limit);
        if (!run_i) begin
            cnt_d = '0;
        end else if (expired_o) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/i2c_tel_engine.sv
module i2c_tel_engine
    import i2c_tel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_i,
    input  logic              scl_lvl,
    input  logic              scl_prev,
    input  logic              sda_lvl,
    input  logic              sda_prev,
    input  logic              expired_i,
    input  logic              req_ack_i,
    input  logic [WORD_W-1:0] req_rdata_i,
    output logic              wait_o,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    output logic              req_valid_o,
    output logic              req_write_o,
    output logic [BYTE_W-1:0] req_sub_o,
    output logic [WORD_W-1:0] req_addr_o,
    output logic [WORD_W-1:0] req_wdata_o
);

    tel_regs_t q, d;
    logic scl_rise, scl_fall, start_ev, stop_ev;

    assign scl_rise = scl_lvl & ~scl_prev;
    assign scl_fall = ~scl_lvl & scl_prev;
    assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

    always_comb begin
        logic byte_ack;
        logic byte_req;
        logic byte_tx;
        logic byte_wr;
        d        = q;
        byte_ack = 1'b0;
        byte_req = 1'b0;
        byte_tx  = 1'b0;
        byte_wr  = 1'b0;
        if (stop_ev) begin
            d.st        = ST_IDLE;
            d.sda_oe    = 1'b0;
            d.scl_oe    = 1'b0;
            d.req_valid = 1'b0;
            d.xfer_err  = 1'b0;
        end else if (start_ev) begin
            d.sda_oe = 1'b0;
            d.bitcnt = '0;
            if (q.xfer_err) begin
                d.st = ST_IGNORE;
            end else begin
                d.st = ST_RX;
                d.ph = PH_DEV;
            end
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        d.shreg  = {q.shreg[BYTE_W-2:0], sda_lvl};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.bitcnt = '0;
                        case (q.ph)
                            PH_DEV: begin
                                if (q.shreg[7:1] == dev_base(strap_i)) begin
                                    byte_ack = 1'b1;
                                    if (q.shreg[0]) begin
                                        byte_tx = 1'b1;
                                        if (q.sub == SUB_CTRL) begin
                                            d.rdbuf   = {q.ctl_rst, q.ctl_err, 14'd0};
                                            d.ctl_rst = 1'b0;
                                        end
                                    end else begin
                                        d.ph = PH_SUB;
                                    end
                                end
                            end
                            PH_SUB: begin
                                if (sub_known(q.shreg)) begin
                                    byte_ack = 1'b1;
                                    d.sub    = q.shreg;
                                    d.ph     = PH_AHI;
                                end
                            end
                            PH_AHI: begin
                                byte_ack     = 1'b1;
                                d.addr[15:8] = q.shreg;
                                d.ph         = PH_ALO;
                            end
                            PH_ALO: begin
                                d.addr[7:0] = q.shreg;
                                d.ph        = PH_DHI;
                                if (sub_is_rd(q.sub)) begin
                                    byte_req = 1'b1;
                                end else begin
                                    byte_ack = 1'b1;
                                end
                            end
                            PH_DHI: begin
                                d.wdata[15:8] = q.shreg;
                                d.ph          = PH_DLO;
                                byte_ack      = !sub_is_rd(q.sub);
                            end
                            PH_DLO: begin
                                d.wdata[7:0] = q.shreg;
                                d.ph         = PH_DONE;
                                if (sub_is_wr(q.sub)) begin
                                    byte_req = 1'b1;
                                    byte_wr  = 1'b1;
                                end else if (q.sub == SUB_CTRL) begin
                                    byte_ack = 1'b1;
                                    if (q.wdata[15]) begin
                                        d.ctl_rst   = 1'b1;
                                        d.ctl_err   = 1'b0;
                                        d.req_valid = 1'b0;
                                    end
                                end
                            end
                            default: ;
                        endcase
                        if (byte_req) begin
                            d.st        = ST_WAIT;
                            d.scl_oe    = 1'b1;
                            d.req_valid = 1'b1;
                            d.req_write = byte_wr;
                        end else if (byte_ack) begin
                            d.st      = ST_ACK;
                            d.sda_oe  = 1'b1;
                            d.tx_mode = byte_tx;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                ST_WAIT: begin
                    if (req_ack_i) begin
                        d.req_valid = 1'b0;
                        d.scl_oe    = 1'b0;
                        d.sda_oe    = 1'b1;
                        d.tx_mode   = 1'b0;
                        d.st        = ST_ACK;
                        if (!q.req_write) begin
                            d.rdbuf = req_rdata_i;
                        end
                    end else if (expired_i) begin
                        d.req_valid = 1'b0;
                        d.scl_oe    = 1'b0;
                        d.sda_oe    = 1'b0;
                        d.ctl_err   = 1'b1;
                        d.xfer_err  = 1'b1;
                        d.st        = ST_IGNORE;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.bitcnt = '0;
                        if (q.tx_mode) begin
                            d.st     = ST_TX;
                            d.shreg  = q.rdbuf[15:8];
                            d.sda_oe = !q.rdbuf[15];
                            d.tx_lo  = 1'b0;
                        end else begin
                            d.st     = ST_RX;
                            d.sda_oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bitcnt == 4'd7) begin
                            d.sda_oe = 1'b0;
                            d.st     = ST_MACK;
                        end else begin
                            d.shreg  = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.sda_oe = !q.shreg[BYTE_W-2];
                            d.bitcnt = q.bitcnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack_ok = !sda_lvl;
                    end else if (scl_fall) begin
                        if (q.mack_ok && !q.tx_lo) begin
                            d.tx_lo  = 1'b1;
                            d.shreg  = q.rdbuf[7:0];
                            d.sda_oe = !q.rdbuf[7];
                            d.bitcnt = '0;
                            d.st     = ST_TX;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                default: begin
                    d.sda_oe = 1'b0;
                    d.scl_oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.ctl_rst <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign wait_o      = (q.st == ST_WAIT);
    assign scl_oe_o    = q.scl_oe;
    assign sda_oe_o    = q.sda_oe;
    assign req_valid_o = q.req_valid;
    assign req_write_o = q.req_write;
    assign req_sub_o   = q.sub;
    assign req_addr_o  = q.addr;
    assign req_wdata_o = q.wdata;

endmodule

// File: rtl/i2c_telegram_slave.sv
module i2c_telegram_slave
    import i2c_tel_pkg::*;
#(
    parameter int NORM_WAIT_CYC = 50000,
    parameter int ERR_WAIT_CYC  = 90000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  strap_sel,
    input  logic        hw_err_i,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        req_valid,
    output logic        req_write,
    output logic [7:0]  req_sub,
    output logic [15:0] req_addr,
    output logic [15:0] req_wdata,
    input  logic        req_ack,
    input  logic [15:0] req_rdata
);

    localparam int N_LINES = 2;
    localparam int IDX_SCL = 0;
    localparam int IDX_SDA = 1;

    logic [N_LINES-1:0] lines_raw, lines_now, lines_prev;
    logic               wait_act;
    logic               expired;

    assign lines_raw[IDX_SCL] = scl_i;
    assign lines_raw[IDX_SDA] = sda_i;

    i2c_tel_line_sync #(
        .N_LINES (N_LINES),
        .STAGES  (SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (lines_raw),
        .line_o      (lines_now),
        .line_prev_o (lines_prev)
    );

    i2c_tel_wait_timer #(
        .NORM_WAIT_CYC (NORM_WAIT_CYC),
        .ERR_WAIT_CYC  (ERR_WAIT_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (wait_act),
        .long_i    (hw_err_i),
        .expired_o (expired)
    );

    i2c_tel_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap_sel),
        .scl_lvl     (lines_now[IDX_SCL]),
        .scl_prev    (lines_prev[IDX_SCL]),
        .sda_lvl     (lines_now[IDX_SDA]),
        .sda_prev    (lines_prev[IDX_SDA]),
        .expired_i   (expired),
        .req_ack_i   (req_ack),
        .req_rdata_i (req_rdata),
        .wait_o      (wait_act),
        .scl_oe_o    (scl_oe),
        .sda_oe_o    (sda_oe),
        .req_valid_o (req_valid),
        .req_write_o (req_write),
        .req_sub_o   (req_sub),
        .req_addr_o  (req_addr),
        .req_wdata_o (req_wdata)
    );

endmodule

// File: rtl/i2c_tel_checker.sv
module i2c_tel_checker #(
    parameter int ERR_WAIT_CYC = 90000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_oe,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_ack,
    input logic [7:0]  req_sub,
    input logic [15:0] req_addr,
    input logic [15:0] req_wdata
);

    localparam int RUN_W = $clog2(ERR_WAIT_CYC + 8);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(ERR_WAIT_CYC + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!scl_oe) begin
            run_q <= '0;
        end else if (run_q != '1) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R5: a pending request always has the clock held
    a_r5_req_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> scl_oe);

    // R4: requests only carry listed internal subaddresses
    a_r4_req_sub_listed: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_sub == 8'h10 || req_sub == 8'h11 ||
                       req_sub == 8'h12 || req_sub == 8'h13));

    // R3: direction matches the subaddress kind (odd = read)
    a_r3_dir_matches_sub: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_write != req_sub[0]));

    // R2: fields hold while waiting
    a_r2_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (!req_valid ||
            ($stable(req_addr) && $stable(req_wdata) && $stable(req_sub))));

    // R2: one acknowledge completes one request
    a_r2_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> !req_valid);

    // R7: no stretch outlasts the long limit
    a_r7_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_MAX);

endmodule

bind i2c_telegram_slave i2c_tel_checker #(
    .ERR_WAIT_CYC (ERR_WAIT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_oe    (scl_oe),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ack   (req_ack),
    .req_sub   (req_sub),
    .req_addr  (req_addr),
    .req_wdata (req_wdata)
);

// File: tb/sim_i2c_telegram_slave.sv
module sim_i2c_telegram_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;
    localparam int NORM_W     = 300;
    localparam int ERR_W      = 540;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap = 2'b00;
    logic        hw_err = 1'b0;
    logic        scl_m_low = 1'b0;
    logic        sda_m_low = 1'b0;
    logic        scl_oe, sda_oe;
    logic        req_valid, req_write;
    logic [7:0]  req_sub;
    logic [15:0] req_addr, req_wdata;
    logic        req_ack;
    logic [15:0] req_rdata;
    wire         scl_bus = !(scl_m_low || scl_oe);
    wire         sda_bus = !(sda_m_low || sda_oe);

    int checks = 0;
    int errors = 0;
    bit stall = 1'b0;
    int n_done = 0;
    int n_seen = 0;
    logic        rv_prev = 1'b0;
    logic [7:0]  last_sub;
    logic [15:0] last_addr, last_data;
    logic        last_wr;
    int run_cnt = 0;
    int max_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_telegram_slave #(
        .NORM_WAIT_CYC (NORM_W),
        .ERR_WAIT_CYC  (ERR_W)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_sel (strap),
        .hw_err_i  (hw_err),
        .scl_i     (scl_bus),
        .sda_i     (sda_bus),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_sub   (req_sub),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ack   (req_ack),
        .req_rdata (req_rdata)
    );

    function automatic logic [15:0] rd_model(input logic [7:0] s, input logic [15:0] a);
        return (a * 16'd3) ^ {s, 8'h5A};
    endfunction

    function automatic logic [7:0] dev_w(input logic [1:0] s);
        case (s)
            2'b00:   return 8'h80;
            2'b01:   return 8'h84;
            default: return 8'h88;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // internal responder
    initial begin
        int dly = 0;
        int tgt = 0;
        req_ack   = 1'b0;
        req_rdata = '0;
        forever begin
            @(negedge clk);
            req_ack = 1'b0;
            if (req_valid && !rv_prev) begin
                n_seen++;
                tgt = $urandom_range(0, 20);
                dly = 0;
            end
            rv_prev = req_valid;
            if (req_valid && !stall) begin
                if (dly >= tgt) begin
                    req_ack   = 1'b1;
                    req_rdata = rd_model(req_sub, req_addr);
                    last_sub  = req_sub;
                    last_addr = req_addr;
                    last_data = req_wdata;
                    last_wr   = req_write;
                    n_done++;
                    dly = 0;
                    tgt = 1000;
                end else begin
                    dly++;
                end
            end
        end
    end

    // stretch length monitor
    always @(posedge clk) begin
        if (scl_oe) begin
            run_cnt <= run_cnt + 1;
            if (run_cnt + 1 > max_run) max_run <= run_cnt + 1;
        end else begin
            run_cnt <= 0;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m_low = 1'b0;
        wait_cyc(HALF);
        scl_m_low = 1'b0;
        while (!scl_bus) @(negedge clk);
        wait_cyc(HALF);
        sda_m_low = 1'b1;
        wait_cyc(HALF);
        scl_m_low = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic m_stop();
        sda_m_low = 1'b1;
        wait_cyc(HALF);
        scl_m_low = 1'b0;
        while (!scl_bus) @(negedge clk);
        wait_cyc(HALF);
        sda_m_low = 1'b0;
        wait_cyc(HALF * 2);
    endtask

    task automatic m_bit(input logic b, output logic r);
        sda_m_low = !b;
        wait_cyc(HALF);
        scl_m_low = 1'b0;
        while (!scl_bus) @(negedge clk);
        wait_cyc(HALF);
        r = sda_bus;
        scl_m_low = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(b[i], r);
        m_bit(1'b1, nack);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic r;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            m_bit(1'b1, r);
            b = {b[6:0], r};
        end
        m_bit(!give_ack, r);
    endtask

    task automatic tel_write(input logic [7:0] dev, input logic [7:0] sub,
                             input logic [15:0] a, input logic [15:0] dt,
                             input bit extra, output logic [6:0] nk);
        nk = '0;
        m_start();
        send_byte(dev, nk[0]);
        send_byte(sub, nk[1]);
        send_byte(a[15:8], nk[2]);
        send_byte(a[7:0], nk[3]);
        send_byte(dt[15:8], nk[4]);
        send_byte(dt[7:0], nk[5]);
        if (extra) send_byte(8'hC3, nk[6]);
        m_stop();
    endtask

    task automatic tel_read(input logic [7:0] dev, input logic [7:0] sub,
                            input logic [15:0] a, output logic [4:0] nk,
                            output logic [15:0] dt);
        logic [7:0] hi, lo;
        m_start();
        send_byte(dev, nk[0]);
        send_byte(sub, nk[1]);
        send_byte(a[15:8], nk[2]);
        send_byte(a[7:0], nk[3]);
        m_start();
        send_byte(dev | 8'h01, nk[4]);
        recv_byte(1'b1, hi);
        recv_byte(1'b0, lo);
        m_stop();
        dt = {hi, lo};
    endtask

    initial begin
        logic [6:0]  wk;
        logic [4:0]  rk;
        logic [15:0] rd;
        logic        nk;
        int          base;
        void'($urandom(32'd20240611));

        // R13: reset state
        wait_cyc(5);
        check(!scl_oe && !sda_oe && !req_valid, "R13 lines released in reset",
              {scl_oe, sda_oe, req_valid}, 0);
        rst_n = 1'b1;
        wait_cyc(5);
        check(!scl_oe && !sda_oe && !req_valid, "R13 lines released after reset",
              {scl_oe, sda_oe, req_valid}, 0);

        // R10: reset flag set after hw reset, cleared by a CONTROL read
        tel_read(dev_w(strap), 8'h00, 16'h0000, rk, rd);
        check(rk == 0 && rd == 16'h8000, "R10 first CONTROL read", {rk, rd}, 16'h8000);
        tel_read(dev_w(strap), 8'h00, 16'h0000, rk, rd);
        check(rd == 16'h0000, "R10 CONTROL read after clear", rd, 16'h0000);

        // R1: address decode for every strap code
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            wait_cyc(4);
            m_start();
            send_byte(dev_w(2'(s + 1)) == dev_w(2'(s)) ? 8'h8C : dev_w(2'(s + 1)), nk);
            m_stop();
            check(nk == 1'b1, "R1 foreign address NACKed", nk, 1);
            m_start();
            send_byte(dev_w(2'(s)), nk);
            m_stop();
            check(nk == 1'b0, "R1 own address ACKed", nk, 0);
        end

        // R4: unlisted subaddress
        strap = 2'b00;
        base = n_seen;
        m_start();
        send_byte(8'h80, wk[0]);
        send_byte(8'h20, wk[1]);
        send_byte(8'h12, wk[2]);
        m_stop();
        check(wk[0] == 0 && wk[1] == 1, "R4 unlisted subaddress NACK", wk[1:0], 2'b01);
        check(wk[2] == 1 && n_seen == base, "R4 following byte ignored", {wk[2], 8'(n_seen - base)}, 9'h100);

        // R2/R3/R5: random telegrams
        for (int i = 0; i < 24; i++) begin
            logic [7:0]  sub;
            logic [15:0] a, dt;
            strap = 2'($urandom_range(0, 3));
            a  = 16'($urandom);
            dt = 16'($urandom);
            wait_cyc(4);
            base = n_done;
            if ($urandom_range(0, 1) == 0) begin
                sub = ($urandom_range(0, 1) == 0) ? 8'h10 : 8'h12;
                tel_write(dev_w(strap), sub, a, dt, 1'b0, wk);
                check(wk[5:0] == 0, "R2 write telegram all ACKed", wk[5:0], 0);
                check(n_done == base + 1 && last_wr && last_sub == sub && last_addr == a &&
                      last_data == dt, "R2 write request content",
                      {last_sub, last_addr}, {sub, a});
            end else begin
                sub = ($urandom_range(0, 1) == 0) ? 8'h11 : 8'h13;
                tel_read(dev_w(strap), sub, a, rk, rd);
                check(rk == 0, "R3 read telegram all ACKed", rk, 0);
                check(rd == rd_model(sub, a) && !last_wr, "R3 read data", rd, rd_model(sub, a));
            end
            check(max_run >= 1 && max_run <= 40, "R5 stretch during request", max_run, 40);
            max_run = 0;
        end

        // R12: extra byte after a full write telegram
        strap = 2'b01;
        wait_cyc(4);
        base = n_seen;
        tel_write(8'h84, 8'h12, 16'h1234, 16'hBEEF, 1'b1, wk);
        check(wk[5:0] == 0 && wk[6] == 1, "R12 seventh byte NACKed", wk, 7'h40);
        check(n_seen == base + 1, "R12 single request", n_seen - base, 1);

        // R6/R8/R9: normal-limit timeout on a read telegram
        stall = 1'b1;
        max_run = 0;
        tel_read(8'h84, 8'h11, 16'h0A0A, rk, rd);
        check(rk[3] == 1, "R6 timed-out byte NACKed", rk[3], 1);
        check(max_run >= NORM_W && max_run <= NORM_W + 2, "R6 normal wait length", max_run, NORM_W);
        check(rk[4] == 1 && rd == 16'hFFFF, "R8 read address NACKed after timeout", {rk[4], rd}, 17'h1FFFF);
        check(!req_valid, "R6 request dropped", req_valid, 0);
        stall = 1'b0;
        tel_read(8'h84, 8'h00, 16'h0000, rk, rd);
        check(rk == 0 && rd == 16'h4000, "R9 error flag after timeout", rd, 16'h4000);

        // R7: long limit with hardware error, on a write
        stall = 1'b1;
        hw_err = 1'b1;
        max_run = 0;
        tel_write(8'h84, 8'h10, 16'h0055, 16'hAA00, 1'b1, wk);
        check(max_run >= ERR_W && max_run <= ERR_W + 2, "R7 error wait length", max_run, ERR_W);
        check(wk[5] == 1 && wk[6] == 1, "R8 remaining bytes NACKed", wk[6:5], 2'b11);
        stall = 1'b0;
        hw_err = 1'b0;

        // R11: CONTROL write without reset bit has no effect
        base = n_seen;
        tel_write(8'h84, 8'h00, 16'h0000, 16'h7FFF, 1'b0, wk);
        tel_read(8'h84, 8'h00, 16'h0000, rk, rd);
        check(wk[5:0] == 0 && rd == 16'h4000, "R11 plain CONTROL write ignored", rd, 16'h4000);
        // R11/R10: software reset
        tel_write(8'h84, 8'h00, 16'h0000, 16'h8000, 1'b0, wk);
        tel_read(8'h84, 8'h00, 16'h0000, rk, rd);
        check(wk[5:0] == 0 && rd == 16'h8000, "R11 software reset flags", rd, 16'h8000);
        check(n_seen == base, "R11 no internal request", n_seen - base, 0);
        tel_read(8'h84, 8'h00, 16'h0000, rk, rd);
        check(rd == 16'h0000, "R10 reset flag cleared by read", rd, 0);

        summary();
        $finish;
    end

endmodule